// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a logical address into a physical address by reading a two-level translation table from memory. A requester hands it a 16-bit logical address. The block cuts the address into three fields: an upper-level index, a lower-level index and a byte offset. It then makes two dependent reads. The first read fetches an upper-level entry, which points at a lower-level table. The second read fetches a lower-level entry, which gives the frame number. The response is the frame number placed above the unchanged offset, or a fault if either entry is marked not present.

The upper-level table starts at the address held in a root register. That register is the only state that changes when the address space changes: software writes a new root and the next walk uses it. Memory is reached through a plain read port. The block raises a one-cycle read strobe with a word address and waits as long as needed for the data strobe. Only one walk runs at a time.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and the root register holds 0.
- R2: With the default widths, the logical address is split as follows: bits [15:12] are the upper-level index, bits [11:8] are the lower-level index, and bits [7:0] are the offset.
- R3: The first read of a walk is at word address root + upper-level index, computed modulo 2^12.
- R4: An upper-level entry is 16 bits. Bit 15 means present, bits [11:0] give the base of the lower-level table, and bits [14:12] are ignored. The second read is at that base + lower-level index, computed modulo 2^12.
- R5: A lower-level entry is 16 bits. Bit 15 means present, bits [7:0] give the frame number, and bits [14:8] are ignored. On success, `rsp_fault` is 0 and `rsp_paddr` = frame × 256 + offset.
- R6: If the upper-level entry is not present, the walk makes exactly one read. It then responds with `rsp_fault`=1, `rsp_fault_lvl`=0 and `rsp_paddr`=0.
- R7: If the lower-level entry is not present, the walk makes exactly two reads. It then responds with `rsp_fault`=1, `rsp_fault_lvl`=1 and `rsp_paddr`=0.
- R8: `req_ready` goes low in the cycle after a request is accepted. It stays low through the response cycle and is high again in the cycle after it. No read is issued while `req_ready` is high.
- R9: `rsp_valid` is a one-cycle pulse. A successful walk responds 4 cycles after the accepting edge when memory returns each datum in the cycle after the read strobe. Every extra cycle of memory latency adds one cycle per read.
- R10: A root write is used by walks accepted after the edge that stores it. A walk already in flight, or one accepted on that same edge, uses the previous root.
- R11: Each read is a one-cycle `mem_req_valid` pulse. The block waits for `mem_rsp_valid` for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_we | input | 1 | Write strobe for the root register |
| root_wdata | input | 12 | New root (word address of the upper-level table) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_laddr | input | 16 | Logical address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk ended on a not-present entry |
| rsp_fault_lvl | output | 1 | Level that faulted: 0 upper, 1 lower |
| rsp_paddr | output | 16 | Physical address (0 on a fault) |
| mem_req_valid | output | 1 | Table read strobe |
| mem_req_addr | output | 12 | Word address of the table read |
| mem_rsp_valid | input | 1 | Table read data strobe |
| mem_rdata | input | 16 | Table read data |

## Verification
The hardest case to reach is a root rewrite that lands while a walk is between its two reads. The walk must keep the root it started with, and the next request must pick up the new one. The bench stretches memory latency to open a wide window mid-walk, writes the root inside that window, and then translates one logical address under each root. The two results differ, and each must match its own table set. Reserved bits set in present entries, and payloads left in not-present entries, confirm that only the present bit and the defined payload field steer the walk.

// File: rtl/pgwalk_pkg.sv
// Shared types for the two-level page table walker.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pgwalk_pkg;

    // Walk controller states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_OUT_REQ = 3'd1,
        ST_OUT_WT  = 3'd2,
        ST_IN_REQ  = 3'd3,
        ST_IN_WT   = 3'd4,
        ST_RESP    = 3'd5
    } walk_state_t;

    // Level reported with a fault
    localparam logic LVL_UPPER = 1'b0;
    localparam logic LVL_LOWER = 1'b1;

endpackage

// File: rtl/pgwalk_split.sv
// Splits a logical address into upper index, lower index and offset.
// Assumes the address width equals the sum of the three field widths.
module pgwalk_split #(
    parameter int OUTER_W = 4,
    parameter int INNER_W = 4,
    parameter int OFF_W   = 8,
    localparam int LA_W   = OUTER_W + INNER_W + OFF_W
) (
    input  logic [LA_W-1:0]    laddr,
    output logic [OUTER_W-1:0] outer_idx,
    output logic [INNER_W-1:0] inner_idx,
    output logic [OFF_W-1:0]   offset
);

    // Field extraction, most significant field first
    always_comb begin
        outer_idx = laddr[LA_W-1 -: OUTER_W];
        inner_idx = laddr[OFF_W +: INNER_W];
        offset    = laddr[OFF_W-1:0];
    end

endmodule

// File: rtl/pgwalk_entry.sv
// Decodes one table entry: the present flag in the top bit, the payload
// in the low bits. Assumes PAYLOAD_W < ENT_W; the bits between are reserved.
module pgwalk_entry #(
    parameter int ENT_W     = 16,
    parameter int PAYLOAD_W = 12
) (
    input  logic [ENT_W-1:0]     word,
    output logic                 present,
    output logic [PAYLOAD_W-1:0] payload
);

    // Present flag and payload field
    always_comb begin
        present = word[ENT_W-1];
        payload = word[PAYLOAD_W-1:0];
    end

endmodule

// File: rtl/pgwalk_fsm.sv
// Walk controller: accepts one request, issues the upper and lower table
// reads in turn, and builds the response. Assumes the memory answers each
// read strobe with exactly one data strobe, after any number of cycles.
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter int OUTER_W = 4,
    parameter int INNER_W = 4,
    parameter int OFF_W   = 8,
    parameter int FRAME_W = 8,
    parameter int MEM_AW  = 12,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [OUTER_W-1:0] outer_idx,
    input  logic [INNER_W-1:0] inner_idx,
    input  logic [OFF_W-1:0]   offset,
    input  logic [MEM_AW-1:0]  root_addr,
    output logic               mem_req_valid,
    output logic [MEM_AW-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic               up_present,
    input  logic [MEM_AW-1:0]  up_next,
    input  logic               lo_present,
    input  logic [FRAME_W-1:0] lo_frame,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic               rsp_fault_lvl,
    output logic [PA_W-1:0]    rsp_paddr
);

    walk_state_t         state_q;
    logic [MEM_AW-1:0]   rd_addr_q;
    logic [INNER_W-1:0]  inner_q;
    logic [OFF_W-1:0]    off_q;
    logic                fault_q;
    logic                lvl_q;
    logic [PA_W-1:0]     paddr_q;

    // State, read address and result registers of the walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_addr_q <= '0;
            inner_q   <= '0;
            off_q     <= '0;
            fault_q   <= 1'b0;
            lvl_q     <= LVL_UPPER;
            paddr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rd_addr_q <= root_addr + MEM_AW'(outer_idx);
                        inner_q   <= inner_idx;
                        off_q     <= offset;
                        fault_q   <= 1'b0;
                        lvl_q     <= LVL_UPPER;
                        paddr_q   <= '0;
                        state_q   <= ST_OUT_REQ;
                    end
                end
                ST_OUT_REQ: state_q <= ST_OUT_WT;
                ST_OUT_WT: begin
                    if (mem_rsp_valid) begin
                        if (up_present) begin
                            rd_addr_q <= up_next + MEM_AW'(inner_q);
                            state_q   <= ST_IN_REQ;
                        end else begin
                            fault_q <= 1'b1;
                            lvl_q   <= LVL_UPPER;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_IN_REQ: state_q <= ST_IN_WT;
                ST_IN_WT: begin
                    if (mem_rsp_valid) begin
                        if (lo_present) begin
                            paddr_q <= {lo_frame, off_q};
                        end else begin
                            fault_q <= 1'b1;
                            lvl_q   <= LVL_LOWER;
                        end
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the current state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_OUT_REQ) || (state_q == ST_IN_REQ);
        mem_req_addr  = rd_addr_q;
        rsp_valid     = (state_q == ST_RESP);
        rsp_fault     = fault_q;
        rsp_fault_lvl = lvl_q;
        rsp_paddr     = paddr_q;
    end

    // R8
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    no_read_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R9
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R11
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

endmodule

// File: rtl/pgwalk_top.sv
// Two-level page table walker top: root register, address split,
// entry decoders for both levels and the walk controller.
// Assumes memory words are entries with the present flag in the top bit.
module pgwalk_top #(
    parameter int OUTER_W = 4,
    parameter int INNER_W = 4,
    parameter int OFF_W   = 8,
    parameter int FRAME_W = 8,
    parameter int MEM_AW  = 12,
    parameter int ENT_W   = 16,
    localparam int LA_W   = OUTER_W + INNER_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_we,
    input  logic [MEM_AW-1:0] root_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LA_W-1:0]   req_laddr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_fault_lvl,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              mem_req_valid,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rdata
);

    logic [MEM_AW-1:0]  root_q;
    logic [OUTER_W-1:0] outer_idx;
    logic [INNER_W-1:0] inner_idx;
    logic [OFF_W-1:0]   offset;
    logic               up_present;
    logic [MEM_AW-1:0]  up_next;
    logic               lo_present;
    logic [FRAME_W-1:0] lo_frame;

    // Root register, rewritten on an address-space switch
    always_ff @(posedge clk) begin
        if (!rst_n) root_q <= '0;
        else if (root_we) root_q <= root_wdata;
    end

    pgwalk_split #(
        .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W)
    ) u_split (
        .laddr(req_laddr), .outer_idx(outer_idx),
        .inner_idx(inner_idx), .offset(offset)
    );

    pgwalk_entry #(.ENT_W(ENT_W), .PAYLOAD_W(MEM_AW)) u_up_ent (
        .word(mem_rdata), .present(up_present), .payload(up_next)
    );

    pgwalk_entry #(.ENT_W(ENT_W), .PAYLOAD_W(FRAME_W)) u_lo_ent (
        .word(mem_rdata), .present(lo_present), .payload(lo_frame)
    );

    pgwalk_fsm #(
        .OUTER_W(OUTER_W), .INNER_W(INNER_W), .OFF_W(OFF_W),
        .FRAME_W(FRAME_W), .MEM_AW(MEM_AW)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .outer_idx(outer_idx), .inner_idx(inner_idx), .offset(offset),
        .root_addr(root_q),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .up_present(up_present), .up_next(up_next),
        .lo_present(lo_present), .lo_frame(lo_frame),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fault_lvl(rsp_fault_lvl), .rsp_paddr(rsp_paddr)
    );

    // R6 R7
    fault_zero_paddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R10
    root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !root_we |=> $stable(root_q));

endmodule

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;

    typedef struct packed {
        logic [11:0] root;
        logic [15:0] laddr;
        logic        fault;
        logic        lvl;
        logic [15:0] paddr;
    } vec_t;

    localparam int NV = 10;
    localparam logic [11:0] ROOT_A = 12'h010;
    localparam logic [11:0] ROOT_B = 12'h020;
    localparam vec_t VECS [NV] = '{
        '{ROOT_A, 16'h0034, 1'b0, 1'b0, 16'h1234},
        '{ROOT_A, 16'h0FAB, 1'b0, 1'b0, 16'hFFAB},
        '{ROOT_A, 16'h01C0, 1'b1, 1'b1, 16'h0000},
        '{ROOT_A, 16'h3207, 1'b0, 1'b0, 16'h0207},
        '{ROOT_A, 16'hFF00, 1'b0, 1'b0, 16'h0000},
        '{ROOT_A, 16'hF7FF, 1'b0, 1'b0, 16'h9CFF},
        '{ROOT_A, 16'h2000, 1'b1, 1'b0, 16'h0000},
        '{ROOT_B, 16'h3512, 1'b0, 1'b0, 16'hAB12},
        '{ROOT_B, 16'h0034, 1'b1, 1'b0, 16'h0000},
        '{ROOT_A, 16'h3512, 1'b1, 1'b1, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        root_we = 1'b0;
    logic [11:0] root_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_laddr = '0;
    logic        rsp_valid, rsp_fault, rsp_fault_lvl;
    logic [15:0] rsp_paddr;
    logic        mem_req_valid;
    logic [11:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rdata = '0;

    logic [15:0] tmem [256];
    int          extra_lat = 0;
    int          rd_cnt = 0;
    logic [11:0] rd_addr [2];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    pgwalk_top u_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fault_lvl(rsp_fault_lvl), .rsp_paddr(rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
    );

    // Table memory model, sampled and driven on falling edges
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
                rd_cnt = rd_cnt + 1;
                mem_rdata = tmem[mem_req_addr[7:0]];
                repeat (extra_lat + 1) @(negedge clk);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic set_root(input logic [11:0] r);
        @(negedge clk);
        root_we = 1'b1; root_wdata = r;
        @(negedge clk);
        root_we = 1'b0;
    endtask

    // Issue one request; return the response and cycles after the accept edge
    task automatic walk(input logic [15:0] la, output logic flt, output logic lvl,
                        output logic [15:0] pa, output int cyc);
        @(negedge clk);
        rd_cnt = 0;
        req_valid = 1'b1; req_laddr = la;
        @(negedge clk);
        req_valid = 1'b0;
        check({31'd0, req_ready}, 32'd0, "R8 ready low after accept");
        cyc = 0;
        while (!rsp_valid) begin
            @(negedge clk);
            cyc++;
        end
        flt = rsp_fault; lvl = rsp_fault_lvl; pa = rsp_paddr;
        check({31'd0, req_ready}, 32'd0, "R8 ready low in response cycle");
        @(negedge clk);
        check({31'd0, req_ready}, 32'd1, "R8 ready back after response");
        check({31'd0, rsp_valid}, 32'd0, "R9 single-cycle response");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) tmem[i] = 16'h0000;
        // root A upper table at 0x010
        tmem[8'h10] = 16'h8040;          // index 0 -> 0x040
        tmem[8'h12] = 16'h0060;          // index 2 not present, payload left set
        tmem[8'h13] = 16'hF050;          // index 3 -> 0x050, reserved bits set
        tmem[8'h1F] = 16'h8060;          // index 15 -> 0x060
        // root B upper table at 0x020
        tmem[8'h23] = 16'h8070;          // index 3 -> 0x070
        // lower tables
        tmem[8'h40] = 16'hF012;          // frame 0x12, reserved bits set
        tmem[8'h41] = 16'h7F33;          // not present
        tmem[8'h4F] = 16'h80FF;
        tmem[8'h52] = 16'h8002;
        tmem[8'h67] = 16'h809C;
        tmem[8'h6F] = 16'h8000;
        tmem[8'h75] = 16'hC0AB;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic        flt, lvl;
        logic [15:0] pa;
        int          cyc;
        logic [11:0] exp_a1;

        repeat (3) @(negedge clk);
        // R1 reset state
        check({31'd0, req_ready}, 32'd1, "R1 ready in reset");
        check({31'd0, rsp_valid}, 32'd0, "R1 rsp_valid in reset");
        check({31'd0, mem_req_valid}, 32'd0, "R1 mem_req_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check({31'd0, req_ready}, 32'd1, "R1 ready after reset");
        // R1 root is zero after reset: the upper index 3 read goes to address 3
        walk(16'h3000, flt, lvl, pa, cyc);
        check({20'd0, rd_addr[0]}, 32'h003, "R1 root zero after reset");
        check({31'd0, flt}, 32'd1, "R6 fault from empty root table");

        // Vector table (R2 R3 R4 R5 R6 R7 R9)
        for (int v = 0; v < NV; v++) begin
            set_root(VECS[v].root);
            walk(VECS[v].laddr, flt, lvl, pa, cyc);
            check({31'd0, flt}, {31'd0, VECS[v].fault}, $sformatf("R5/R6/R7 fault v%0d", v));
            check({16'd0, pa}, {16'd0, VECS[v].paddr}, $sformatf("R2/R5 paddr v%0d", v));
            if (VECS[v].fault)
                check({31'd0, lvl}, {31'd0, VECS[v].lvl}, $sformatf("R6/R7 level v%0d", v));
            exp_a1 = VECS[v].root + 12'(VECS[v].laddr[15:12]);
            check({20'd0, rd_addr[0]}, {20'd0, exp_a1}, $sformatf("R3 first read v%0d", v));
            if (VECS[v].fault && !VECS[v].lvl) begin
                check(32'(rd_cnt), 32'd1, $sformatf("R6 one read v%0d", v));
            end else begin
                check(32'(rd_cnt), 32'd2, $sformatf("R7 two reads v%0d", v));
                check({20'd0, rd_addr[1]},
                      {20'd0, tmem[exp_a1[7:0]][11:0] + 12'(VECS[v].laddr[11:8])},
                      $sformatf("R4 second read v%0d", v));
            end
            if (!VECS[v].fault) check(32'(cyc), 32'd4, $sformatf("R9 latency v%0d", v));
        end

        // R9 R11: stretched memory latency adds one cycle per read
        set_root(ROOT_A);
        extra_lat = 3;
        walk(16'h0034, flt, lvl, pa, cyc);
        check(32'(cyc), 32'd10, "R9 R11 latency with slow memory");
        check({16'd0, pa}, 32'h1234, "R11 result with slow memory");

        // R10: root rewritten mid-walk does not disturb the walk in flight
        @(negedge clk);
        rd_cnt = 0;
        req_valid = 1'b1; req_laddr = 16'h3512;
        @(negedge clk);
        req_valid = 1'b0;
        root_we = 1'b1; root_wdata = ROOT_B;
        @(negedge clk);
        root_we = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check({31'd0, rsp_fault}, 32'd1, "R10 in-flight walk keeps old root");
        check({31'd0, rsp_fault_lvl}, 32'd1, "R10 in-flight fault level");
        extra_lat = 0;
        walk(16'h3512, flt, lvl, pa, cyc);
        check({16'd0, pa}, 32'hAB12, "R10 next walk uses new root");

        // R10: root write on the accepting edge is not seen by that walk
        @(negedge clk);
        req_valid = 1'b1; req_laddr = 16'h0034;
        root_we = 1'b1; root_wdata = ROOT_A;
        @(negedge clk);
        req_valid = 1'b0; root_we = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check({31'd0, rsp_fault}, 32'd1, "R10 same-edge write uses old root");
        walk(16'h0034, flt, lvl, pa, cyc);
        check({16'd0, pa}, 32'h1234, "R10 write applies afterwards");

        finish_run();
    end

endmodule